// File: doc/BRIEF.md
# Single-Cycle Store Path for a Direct-Mapped Data Cache

This block is the store and load path of a small direct-mapped data cache. Every store finishes within one memory-stage cycle. It does this by splitting the store into two halves. In the cycle a store arrives, only its tag is checked. The data of the store that came before it, which has been waiting in a one-entry holding register, is written into the data array during that same cycle. A store that hits takes the freed holding register. A store that misses is dropped, following a no-write-allocate policy, and the register stays empty.

Loads read the tag and data arrays in the same cycle they are presented. If the pending store covers the load's word, the load sees that store's bytes, merged byte by byte over the array contents. A refill port lets the surrounding miss logic place one word at a time into the arrays. Each placed word stamps the line's tag and sets its valid flag. Refill sequencing and traffic to the next level of memory live outside this block.

The default geometry is 1 KB with 32-byte lines and 32-bit words.

Top module: `cwb_store_path`

## Requirements
- R1: After reset, every line is invalid and the holding register is empty, so every load reports `ld_hit` low.
- R2: The address splits as follows. Bits [31:10] are the tag, bits [9:5] are the line index, bits [4:2] are the word in the line, and bits [1:0] are ignored. A load hits only when the indexed line is valid and its stored tag equals the address tag.
- R3: A load that hits returns the stored word on `ld_data` in the cycle it is presented. `ld_hit` is high only for loads.
- R4: A store that hits is held in the holding register. A later load to the same word address returns the held bytes where the held byte enables are 1, and the array bytes where they are 0. Loads to any other word are not affected.
- R5: On the next store cycle, the held store is written into the array (enabled bytes only). This happens whether the new store hits or misses. Afterwards, loads to that word return the written bytes from the array.
- R6: A store that misses writes nothing into the array and leaves the holding register empty.
- R7: A load changes neither the holding register nor the array.
- R8: Stores on consecutive cycles each complete in their own cycle. No stall signal exists, and no store is lost.
- R9: A refill writes one full word, stamps the line's tag and sets its valid flag. A refill into the line index of the held store empties the register without writing the held data. A refill into any other line leaves the register untouched.
- R10: Loads ignore `req_wdata` and `req_be`, and always return the full word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables, bit n covers bits [8n+7:8n] |
| fill_en | input | 1 | Refill one word this cycle |
| fill_addr | input | 32 | Byte address of the refilled word |
| fill_data | input | 32 | Refilled word |
| ld_hit | output | 1 | Load found its line valid with a matching tag |
| ld_data | output | 32 | Load result, holding-register bytes merged over the array word |

## Verification
The assertions rely on one input rule: a refill and a request never share a cycle. The surrounding miss logic owns the array port during a refill. The check that a load leaves the holding register stable also depends on that separation. The bench keeps to this rule by driving each cycle from exactly one task, which raises either the request or the refill signal and clears the other. The bench also sweeps a narrow band of indices, words and two tags, so that hits, misses, same-word overwrites and refills over a held store all happen often.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  localparam int unsigned CWB_ADDR_W      = 32;
  localparam int unsigned CWB_DATA_W      = 32;
  localparam int unsigned CWB_CACHE_BYTES = 1024;
  localparam int unsigned CWB_LINE_BYTES  = 32;

  typedef enum logic {
    REQ_LOAD  = 1'b0,
    REQ_STORE = 1'b1
  } req_kind_e;
endpackage

// File: rtl/cwb_tag_array.sv
module cwb_tag_array #(
  parameter int IDX_W = 5,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag
);
  localparam int NUM_LINES = 1 << IDX_W;

  logic [TAG_W-1:0]     tag_q [NUM_LINES];
  logic [NUM_LINES-1:0] vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vld_q <= '0;
    else if (fill_en) vld_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  // R9: a refill leaves its line valid and carrying the refill tag
  a_r9_fill_marks_line: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> vld_q[$past(fill_idx)] && (tag_q[$past(fill_idx)] == $past(fill_tag)));
endmodule

// File: rtl/cwb_data_array.sv
module cwb_data_array #(
  parameter int WIDX_W = 8,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_widx,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [WIDX_W-1:0] rd_widx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH  = 1 << WIDX_W;
  localparam int BYTE_W = DATA_W / BE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BE_W; b++) begin
        if (wr_be[b]) mem_q[wr_widx][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rd_data = mem_q[rd_widx];
endmodule

// File: rtl/cwb_store_buffer.sv
module cwb_store_buffer #(
  parameter int WADDR_W = 30,
  parameter int DATA_W  = 32,
  parameter int BE_W    = 4,
  parameter int IDX_W   = 5,
  parameter int WSEL_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      st_go,
  input  logic                      st_hit,
  input  logic [WADDR_W-1:0]        st_waddr,
  input  logic [DATA_W-1:0]         st_data,
  input  logic [BE_W-1:0]           st_be,
  input  logic                      fill_en,
  input  logic [IDX_W-1:0]          fill_idx,
  input  logic [WADDR_W-1:0]        probe_waddr,
  output logic                      buf_valid,
  output logic                      ret_en,
  output logic [IDX_W+WSEL_W-1:0]   ret_widx,
  output logic [DATA_W-1:0]         ret_data,
  output logic [BE_W-1:0]           ret_be,
  output logic [BE_W-1:0]           fwd_be,
  output logic [DATA_W-1:0]         fwd_data
);
  localparam int WIDX_W = IDX_W + WSEL_W;

  logic               valid_q;
  logic [WADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0]  data_q;
  logic [BE_W-1:0]    be_q;
  logic               drop;

  // refill landing on the held store's line discards it
  assign drop = fill_en && valid_q && (waddr_q[WSEL_W +: IDX_W] == fill_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid_q <= 1'b0;
    else if (st_go) valid_q <= st_hit;
    else if (drop)  valid_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (st_go && st_hit) begin
      waddr_q <= st_waddr;
      data_q  <= st_data;
      be_q    <= st_be;
    end
  end

  assign buf_valid = valid_q;
  assign ret_en    = st_go && valid_q;
  assign ret_widx  = waddr_q[WIDX_W-1:0];
  assign ret_data  = data_q;
  assign ret_be    = be_q;
  assign fwd_be    = (valid_q && (probe_waddr == waddr_q)) ? be_q : '0;
  assign fwd_data  = data_q;

  // R4: a hitting store is held with its address and data
  a_r4_hit_captures: assert property (@(posedge clk) disable iff (!rst_n)
    (st_go && st_hit) |=> valid_q && (waddr_q == $past(st_waddr)) && (data_q == $past(st_data)));
  // R6: a missing store leaves the register empty
  a_r6_miss_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (st_go && !st_hit) |=> !valid_q);
  // R9: refill over the held line discards the held store
  a_r9_drop_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !st_go) |=> !valid_q);
endmodule

// File: rtl/cwb_store_path.sv
module cwb_store_path
  import cwb_pkg::*;
#(
  parameter int ADDR_W      = CWB_ADDR_W,
  parameter int DATA_W      = CWB_DATA_W,
  parameter int CACHE_BYTES = CWB_CACHE_BYTES,
  parameter int LINE_BYTES  = CWB_LINE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data
);
  localparam int BE_W      = DATA_W / 8;
  localparam int BSEL_W    = $clog2(BE_W);
  localparam int OFFS_W    = $clog2(LINE_BYTES);
  localparam int NUM_LINES = CACHE_BYTES / LINE_BYTES;
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int TAG_W     = ADDR_W - IDX_W - OFFS_W;
  localparam int WSEL_W    = OFFS_W - BSEL_W;
  localparam int WIDX_W    = IDX_W + WSEL_W;
  localparam int WADDR_W   = ADDR_W - BSEL_W;

  function automatic logic [TAG_W-1:0] fn_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] fn_idx(input logic [ADDR_W-1:0] a);
    return a[OFFS_W +: IDX_W];
  endfunction
  function automatic logic [WIDX_W-1:0] fn_widx(input logic [ADDR_W-1:0] a);
    return a[BSEL_W +: WIDX_W];
  endfunction
  function automatic logic [WADDR_W-1:0] fn_waddr(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: WADDR_W];
  endfunction
  function automatic logic [DATA_W-1:0] fn_merge(input logic [DATA_W-1:0] base,
                                                 input logic [DATA_W-1:0] over,
                                                 input logic [BE_W-1:0]   sel);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < BE_W; b++) r[b*8 +: 8] = sel[b] ? over[b*8 +: 8] : base[b*8 +: 8];
    return r;
  endfunction

  req_kind_e kind;
  logic is_store, is_load, tag_hit;
  logic buf_valid, ret_en;
  logic [WIDX_W-1:0] ret_widx;
  logic [DATA_W-1:0] ret_data, fwd_data, rd_data;
  logic [BE_W-1:0]   ret_be, fwd_be;

  assign kind     = req_kind_e'(req_we);
  assign is_store = req_valid && (kind == REQ_STORE);
  assign is_load  = req_valid && (kind == REQ_LOAD);

  cwb_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(fn_idx(req_addr)), .lk_tag(fn_tag(req_addr)), .lk_hit(tag_hit),
    .fill_en(fill_en), .fill_idx(fn_idx(fill_addr)), .fill_tag(fn_tag(fill_addr))
  );

  cwb_store_buffer #(.WADDR_W(WADDR_W), .DATA_W(DATA_W), .BE_W(BE_W),
                     .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_sbuf (
    .clk(clk), .rst_n(rst_n),
    .st_go(is_store), .st_hit(tag_hit), .st_waddr(fn_waddr(req_addr)),
    .st_data(req_wdata), .st_be(req_be),
    .fill_en(fill_en), .fill_idx(fn_idx(fill_addr)),
    .probe_waddr(fn_waddr(req_addr)),
    .buf_valid(buf_valid), .ret_en(ret_en), .ret_widx(ret_widx),
    .ret_data(ret_data), .ret_be(ret_be), .fwd_be(fwd_be), .fwd_data(fwd_data)
  );

  // refill and retirement never overlap (refill owns the port on its cycles)
  cwb_data_array #(.WIDX_W(WIDX_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_data (
    .clk(clk),
    .wr_en(fill_en || ret_en),
    .wr_widx(fill_en ? fn_widx(fill_addr) : ret_widx),
    .wr_be(fill_en ? {BE_W{1'b1}} : ret_be),
    .wr_data(fill_en ? fill_data : ret_data),
    .rd_widx(fn_widx(req_addr)),
    .rd_data(rd_data)
  );

  assign ld_hit  = is_load && tag_hit;
  assign ld_data = fn_merge(rd_data, fwd_data, fwd_be);

  // R7: a load leaves the holding register as it was
  a_r7_load_keeps_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && !fill_en) |=> $stable(buf_valid));
  // R9: refill cycles carry no request
  a_r9_fill_excludes_req: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !req_valid);
endmodule

// File: tb/sim_cwb_store_path.sv
module sim_cwb_store_path;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_we, fill_en, ld_hit;
  logic [31:0] req_addr, req_wdata, fill_addr, fill_data, ld_data;
  logic [3:0]  req_be;

  cwb_store_path u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
    .ld_hit(ld_hit), .ld_data(ld_data)
  );

  localparam logic [21:0] T0 = 22'h0002A5;
  localparam logic [21:0] T1 = 22'h00133C;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  // reference state built from the requirements
  logic [31:0] m_mem [256];
  logic [21:0] m_tag [32];
  logic [31:0] m_vld;
  logic        m_bv;
  logic [29:0] m_ba;
  logic [31:0] m_bd;
  logic [3:0]  m_bbe;

  function automatic logic [31:0] mk(input logic [21:0] t, input int idx, input int w);
    return {t, idx[4:0], w[2:0], 2'b00};
  endfunction
  function automatic logic [31:0] pat(input int widx);
    return 32'h3C00_0000 ^ (widx * 32'h0001_0101);
  endfunction
  function logic [31:0] nxt();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction
  function automatic logic m_hit(input logic [31:0] a);
    return m_vld[a[9:5]] && (m_tag[a[9:5]] == a[31:10]);
  endfunction
  function automatic logic [31:0] m_load(input logic [31:0] a);
    logic [31:0] r;
    r = m_mem[a[9:2]];
    for (int b = 0; b < 4; b++)
      if (m_bv && (m_ba == a[31:2]) && m_bbe[b]) r[b*8 +: 8] = m_bd[b*8 +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic drive_load(input logic [31:0] a, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a; req_wdata = nxt(); req_be = be; fill_en = 1'b0;
    #1;
  endtask

  task automatic load_vs_model(input logic [31:0] a, input string r);
    logic eh;
    drive_load(a, nxt() & 32'hF);
    eh = m_hit(a);
    check(ld_hit == eh, r, {31'd0, ld_hit}, {31'd0, eh});
    if (eh) check(ld_data == m_load(a), r, ld_data, m_load(a));
  endtask

  task automatic op_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    logic h;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d; req_be = be; fill_en = 1'b0;
    h = m_hit(a);
    @(posedge clk);
    if (m_bv)
      for (int b = 0; b < 4; b++) if (m_bbe[b]) m_mem[m_ba[7:0]][b*8 +: 8] = m_bd[b*8 +: 8];
    m_bv = h;
    if (h) begin m_ba = a[31:2]; m_bd = d; m_bbe = be; end
  endtask

  task automatic op_fill(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0; fill_en = 1'b1; fill_addr = a; fill_data = d;
    @(posedge clk);
    m_mem[a[9:2]] = d; m_tag[a[9:5]] = a[31:10]; m_vld[a[9:5]] = 1'b1;
    if (m_bv && (m_ba[7:3] == a[9:5])) m_bv = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; fill_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired before all requirements were exercised");
      finish_run();
    end
  end

  initial begin
    logic [31:0] a, b2, c, e, exp;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    fill_en = 1'b0; fill_addr = '0; fill_data = '0;
    m_vld = '0; m_bv = 1'b0; m_ba = '0; m_bd = '0; m_bbe = '0;
    for (int i = 0; i < 256; i++) m_mem[i] = '0;
    for (int i = 0; i < 32; i++) m_tag[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: nothing hits after reset
    for (int i = 0; i < 4; i++) begin
      drive_load(mk(T0, i * 7, i), 4'hF);
      check(ld_hit == 1'b0, "R1 reset leaves lines invalid", {31'd0, ld_hit}, 32'd0);
    end

    // R9 fill every word, R2/R3 read back every word
    for (int w = 0; w < 256; w++) op_fill(mk(T0, w / 8, w % 8), pat(w));
    for (int w = 0; w < 256; w++) begin
      drive_load(mk(T0, w / 8, w % 8), 4'hF);
      check(ld_hit && ld_data == pat(w), "R3 load returns stored word", ld_data, pat(w));
    end
    // R2: other tag misses on every line, low address bits ignored
    for (int i = 0; i < 32; i++) begin
      drive_load(mk(T1, i, 2), 4'hF);
      check(ld_hit == 1'b0, "R2 tag mismatch misses", {31'd0, ld_hit}, 32'd0);
    end
    drive_load(mk(T0, 4, 6) | 32'd3, 4'hF);
    check(ld_hit && ld_data == pat(38), "R2 byte offset ignored", ld_data, pat(38));
    // R10: load ignores byte enables
    drive_load(mk(T0, 5, 1), 4'h0);
    check(ld_hit && ld_data == pat(41), "R10 load returns full word", ld_data, pat(41));
    // R3: a store cycle never raises ld_hit
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = mk(T1, 30, 0); req_be = 4'h0; fill_en = 1'b0;
    #1 check(ld_hit == 1'b0, "R3 ld_hit only for loads", {31'd0, ld_hit}, 32'd0);
    @(posedge clk);
    m_bv = 1'b0;  // that store missed: register empty, nothing written

    // R4: partial store forwarded per byte
    a = mk(T0, 3, 5);
    op_store(a, 32'hAABBCCDD, 4'b0101);
    exp = {pat(29)[31:24], 8'hBB, pat(29)[15:8], 8'hDD};
    drive_load(a, 4'hF);
    check(ld_hit && ld_data == exp, "R4 byte merge of held store", ld_data, exp);
    drive_load(mk(T0, 3, 6), 4'hF);
    check(ld_data == pat(30), "R4 neighbour word unaffected", ld_data, pat(30));
    // R7: repeated loads leave the held store in place
    drive_load(a, 4'hF);
    check(ld_data == exp, "R7 load keeps held store", ld_data, exp);

    // R5: next store retires the held one
    b2 = mk(T0, 9, 1);
    op_store(b2, 32'h11223344, 4'hF);
    drive_load(a, 4'hF);
    check(ld_data == exp, "R5 retired bytes in array", ld_data, exp);
    drive_load(b2, 4'hF);
    check(ld_data == 32'h11223344, "R4 full-word held store", ld_data, 32'h11223344);

    // R6: store miss writes nothing, still retires the held store
    c = mk(T1, 9, 1);
    op_store(c, 32'hDEAD0001, 4'hF);
    drive_load(b2, 4'hF);
    check(ld_hit && ld_data == 32'h11223344, "R6 miss leaves array word", ld_data, 32'h11223344);
    drive_load(c, 4'hF);
    check(ld_hit == 1'b0, "R6 miss does not allocate", {31'd0, ld_hit}, 32'd0);
    op_store(a, 32'h55667788, 4'b1000);
    exp = {8'h55, 8'hBB, pat(29)[15:8], 8'hDD};
    drive_load(a, 4'hF);
    check(ld_data == exp, "R6 register empty after miss then overwrite", ld_data, exp);

    // R8: back-to-back stores all land
    for (int w = 0; w < 8; w++) op_store(mk(T0, 12, w), 32'h7700_0000 | w, 4'hF);
    idle();
    for (int w = 0; w < 8; w++) begin
      drive_load(mk(T0, 12, w), 4'hF);
      check(ld_data == (32'h7700_0000 | w), "R8 consecutive store kept", ld_data, 32'h7700_0000 | w);
    end

    // R9: refill over the held line discards it
    e = mk(T0, 20, 2);
    op_store(e, 32'hCAFEF00D, 4'hF);
    op_fill(e, 32'h0BADBEEF);
    drive_load(e, 4'hF);
    check(ld_data == 32'h0BADBEEF, "R9 refill drops held store", ld_data, 32'h0BADBEEF);
    op_store(mk(T0, 21, 0), 32'h01020304, 4'hF);
    drive_load(e, 4'hF);
    check(ld_data == 32'h0BADBEEF, "R9 dropped store never retired", ld_data, 32'h0BADBEEF);
    op_store(mk(T0, 22, 4), 32'h600D600D, 4'hF);
    op_fill(mk(T0, 23, 0), 32'h0F0F0F0F);
    drive_load(mk(T0, 22, 4), 4'hF);
    check(ld_data == 32'h600D600D, "R9 refill elsewhere keeps held store", ld_data, 32'h600D600D);

    // R3/R4/R5/R6/R9 mixed sweep over a narrow address band
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r, ad;
      r  = nxt();
      ad = mk(r[0] ? T0 : T1, r[3:1], r[6:4]) | {30'd0, r[12:11]};
      case (r[9:8])
        2'd0, 2'd1: load_vs_model(ad, "R3/R4/R5 sweep load");
        2'd2:       op_store(ad, nxt(), r[16:13]);
        default:    if (r[10]) op_fill(ad, nxt()); else op_store(ad, nxt(), r[16:13]);
      endcase
    end
    for (int w = 0; w < 64; w++) load_vs_model(mk(T0, w / 8, w % 8), "R5/R6 sweep readback");

    done = 1'b1;
    finish_run();
  end
endmodule